// File: doc/BRIEF.md
# Dual-Width Burst ROM Read Port

This block is a clock-driven model of a read-only array that a host reads either as 16-bit words or as single bytes. A width-select input picks the view. In byte view a separate input acts as the lowest byte-address bit. It chooses the low byte of the stored word when it is 0 and the high byte when it is 1. The full address space spans 2^18 words or 2^19 bytes. The stored contents are held in a parameterised array of 2^ARRAY_AW words, and the upper address bits alias onto it.

A read becomes valid a set number of clocks after its address settles. A read that leaves the address bits above bit 1 untouched stays inside an aligned group of four words or eight bytes. Such a read uses a short burst latency. Any other read uses the full latency, which is twice as long by default.

Output enable gates the data lanes without restarting a read. Dropping chip enable puts the block in standby. An identifier flag returns two fixed codes instead of array data. A backdoor port writes stored words, and an erase command sets every stored bit to 1.

Top module: `rom_burst_port`

## Requirements
- R1: In word view (`word_mode`=1) a completed read returns the stored word at `addr`. Storage is indexed by `addr[ARRAY_AW-1:0]`, so addresses that differ only above that field return the same word.
- R2: In byte view (`word_mode`=0) a completed read returns the low byte of word `addr` when `byte_lsb`=0 and the high byte when `byte_lsb`=1, on `rd_data[7:0]`. In byte view `drive_hi` stays 0 and `rd_data[15:8]` reads 0.
- R3: A read whose `addr[17:2]`, width view or identifier flag differs from the previously tracked read, or that follows standby or reset, raises `rd_valid` on the FULL_LAT-th rising edge. The first edge that samples the new inputs counts as edge 1, and the default is 4.
- R4: A read that changes only `addr[1:0]` (plus `byte_lsb` in byte view) inside the tracked group raises `rd_valid` on the BURST_LAT-th rising edge (default 2).
- R5: `rd_valid` is 0 out of reset and from the first edge that samples a new read until that read completes.
- R6: With `chip_en`=0, `rd_valid` falls at the next edge and address changes are ignored. The next read after standby takes the full latency even if it falls in the previous group.
- R7: With `out_en`=0, `drive_lo`, `drive_hi` and `rd_data` are 0 in the same cycle. Toggling `out_en` does not restart a completed read.
- R8: A one-cycle `erase_all` sets every stored bit to 1, so any word then reads 0xFFFF. Reset leaves the array in the same erased state.
- R9: With `id_mode`=1, a read returns 0x07 on `rd_data[7:0]` when `addr[0]`=0 and 0xA1 when `addr[0]`=1, with 0 on the upper byte.
- R10: In word view `byte_lsb` has no effect: changing it neither restarts the read nor alters `rd_data`.
- R11: `bd_we`=1 writes `bd_data` into word `bd_addr[ARRAY_AW-1:0]` at the clock edge. `erase_all` wins if both are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en | input | 1 | Chip enable, active high; low means standby |
| out_en | input | 1 | Output enable, active high |
| word_mode | input | 1 | 1 selects the 16-bit view, 0 selects the byte view |
| id_mode | input | 1 | 1 returns identifier codes instead of array data |
| addr | input | 18 | Word address; in byte view, the byte address above bit 0 |
| byte_lsb | input | 1 | Lowest byte-address bit, used in byte view only |
| bd_we | input | 1 | Backdoor write strobe |
| bd_addr | input | 18 | Backdoor word address |
| bd_data | input | 16 | Backdoor write data |
| erase_all | input | 1 | Sets every stored bit to 1 |
| rd_data | output | 16 | Read data, 0 on lanes that are not driven |
| rd_valid | output | 1 | Current read has completed |
| drive_lo | output | 1 | Low data byte is driven |
| drive_hi | output | 1 | High data byte is driven |

## Verification
The hardest case to reach from the ports is a read that lands in the group just tracked but must still take the full latency. Two things cause it: an interval of standby and a width-view change. Neither shows up in the address. The stimulus first settles a byte-view burst inside one group. It then drops chip enable and moves the low address bits during standby. Finally it re-enables at a neighbouring byte of the same group and expects the four-clock timing. The word-view `byte_lsb` toggle and the output-enable toggle are held for several edges after a read completes, to show that `rd_valid` never drops.

// File: rtl/rom_pkg.sv
// Shared constants for the dual-width ROM read port.
// Assumes an 8-bit byte lane and fixed identifier codes.
package rom_pkg;
    localparam logic [7:0] MFR_CODE = 8'h07;
    localparam logic [7:0] DEV_CODE = 8'hA1;
    localparam int         GROUP_BITS = 2;
endpackage

// File: rtl/rom_store.sv
// Word storage array with a backdoor write and a bulk erase.
// Assumes ARRAY_AW <= ADDR_W; upper address bits alias onto the array.
// Reset and erase both return every bit to 1 (the erased state).
module rom_store #(
    parameter int ADDR_W   = 18,
    parameter int ARRAY_AW = 10,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_all,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ARRAY_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Update storage: erase or reset fills with ones, else apply a backdoor write.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_all) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (wr_en) begin
            mem[wr_addr[ARRAY_AW-1:0]] <= wr_data;
        end
    end

    // Asynchronous array read on the current access address.
    assign rd_word = mem[rd_addr[ARRAY_AW-1:0]];
endmodule

// File: rtl/rom_access_track.sv
// Tracks the current read and its burst group, and counts its latency.
// A read is a new access when any key field changes; it is a burst when
// only the in-group low bits changed. Assumes FULL_LAT >= BURST_LAT >= 1.
module rom_access_track #(
    parameter int ADDR_W    = 18,
    parameter int FULL_LAT  = 4,
    parameter int BURST_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              word_mode,
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_lsb,
    output logic              capture,
    output logic              rd_valid
);
    import rom_pkg::*;

    localparam int UP_W  = ADDR_W - GROUP_BITS;
    localparam int KEY_W = ADDR_W + 3;
    localparam int CNT_W = $clog2(FULL_LAT + 1);
    localparam logic [CNT_W-1:0] FULL_LD  = CNT_W'(FULL_LAT - 1);
    localparam logic [CNT_W-1:0] BURST_LD = CNT_W'(BURST_LAT - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [KEY_W-1:0] key_now, key_q;
    logic [UP_W-1:0]  trk_upper;
    logic             trk_word, trk_id, trk_vld;
    logic [CNT_W-1:0] cnt_q, load_val;
    logic             key_chg, grp_same;

    // Form the access key; byte_lsb counts only in byte view.
    assign key_now = {word_mode, id_mode, addr, byte_lsb & ~word_mode};

    // Classify the sampled read against the tracked group.
    always_comb begin
        key_chg  = !trk_vld || (key_now != key_q);
        grp_same = trk_vld && (addr[ADDR_W-1:GROUP_BITS] == trk_upper)
                   && (word_mode == trk_word) && (id_mode == trk_id);
        load_val = grp_same ? BURST_LD : FULL_LD;
        capture  = chip_en && ((key_chg && load_val == '0) ||
                               (!key_chg && cnt_q == CNT_ONE));
    end

    // Advance tracking state, latency counter and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_vld   <= 1'b0;
            key_q     <= '0;
            trk_upper <= '0;
            trk_word  <= 1'b0;
            trk_id    <= 1'b0;
            cnt_q     <= '0;
            rd_valid  <= 1'b0;
        end else if (!chip_en) begin
            trk_vld  <= 1'b0;
            cnt_q    <= '0;
            rd_valid <= 1'b0;
        end else if (key_chg) begin
            trk_vld   <= 1'b1;
            key_q     <= key_now;
            trk_upper <= addr[ADDR_W-1:GROUP_BITS];
            trk_word  <= word_mode;
            trk_id    <= id_mode;
            cnt_q     <= load_val;
            rd_valid  <= (load_val == '0);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_ONE;
            if (cnt_q == CNT_ONE) begin
                rd_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rom_lane_mux.sv
// Formats read data for the selected view, holds it, and gates the lanes.
// Assumes the read inputs are stable in the cycle capture is high.
module rom_lane_mux #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                word_mode,
    input  logic                id_mode,
    input  logic                addr_lsb,
    input  logic                byte_lsb,
    input  logic [2*BYTE_W-1:0] rd_word,
    input  logic                out_en,
    input  logic                valid,
    output logic [2*BYTE_W-1:0] rd_data,
    output logic                drive_lo,
    output logic                drive_hi
);
    import rom_pkg::*;

    localparam int DATA_W = 2 * BYTE_W;

    logic [DATA_W-1:0] fmt, data_q;
    logic              wide_q;

    // Pick identifier code, full word, or the addressed byte.
    always_comb begin
        if (id_mode) begin
            fmt = DATA_W'(addr_lsb ? DEV_CODE : MFR_CODE);
        end else if (word_mode) begin
            fmt = rd_word;
        end else begin
            fmt = {{BYTE_W{1'b0}},
                   byte_lsb ? rd_word[DATA_W-1:BYTE_W] : rd_word[BYTE_W-1:0]};
        end
    end

    // Hold the formatted data and view of the completed read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            wide_q <= 1'b0;
        end else if (capture) begin
            data_q <= fmt;
            wide_q <= word_mode;
        end
    end

    // Gate each lane; undriven lanes read as zero.
    always_comb begin
        drive_lo = valid && out_en;
        drive_hi = drive_lo && wide_q;
        rd_data  = {drive_hi ? data_q[DATA_W-1:BYTE_W] : {BYTE_W{1'b0}},
                    drive_lo ? data_q[BYTE_W-1:0]      : {BYTE_W{1'b0}}};
    end
endmodule

// File: rtl/rom_burst_port.sv
// Top of the dual-width burst ROM read port: storage, access tracking and
// output lanes. Assumes a single clock and synchronous active-low reset.
module rom_burst_port #(
    parameter int ADDR_W    = 18,
    parameter int ARRAY_AW  = 10,
    parameter int BYTE_W    = 8,
    parameter int FULL_LAT  = 4,
    parameter int BURST_LAT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chip_en,
    input  logic                out_en,
    input  logic                word_mode,
    input  logic                id_mode,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                byte_lsb,
    input  logic                bd_we,
    input  logic [ADDR_W-1:0]   bd_addr,
    input  logic [2*BYTE_W-1:0] bd_data,
    input  logic                erase_all,
    output logic [2*BYTE_W-1:0] rd_data,
    output logic                rd_valid,
    output logic                drive_lo,
    output logic                drive_hi
);
    localparam int DATA_W = 2 * BYTE_W;

    logic [DATA_W-1:0] rd_word;
    logic              capture;

    rom_store #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_all (erase_all),
        .wr_en     (bd_we),
        .wr_addr   (bd_addr),
        .wr_data   (bd_data),
        .rd_addr   (addr),
        .rd_word   (rd_word)
    );

    rom_access_track #(.ADDR_W(ADDR_W), .FULL_LAT(FULL_LAT), .BURST_LAT(BURST_LAT)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_en   (chip_en),
        .word_mode (word_mode),
        .id_mode   (id_mode),
        .addr      (addr),
        .byte_lsb  (byte_lsb),
        .capture   (capture),
        .rd_valid  (rd_valid)
    );

    rom_lane_mux #(.BYTE_W(BYTE_W)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .word_mode (word_mode),
        .id_mode   (id_mode),
        .addr_lsb  (addr[0]),
        .byte_lsb  (byte_lsb),
        .rd_word   (rd_word),
        .out_en    (out_en),
        .valid     (rd_valid),
        .rd_data   (rd_data),
        .drive_lo  (drive_lo),
        .drive_hi  (drive_hi)
    );
endmodule

// File: rtl/rom_burst_port_chk.sv
// Port-level checker for rom_burst_port, attached by bind.
// Assumes the same parameters as the bound instance.
module rom_burst_port_chk #(
    parameter int ADDR_W   = 18,
    parameter int BYTE_W   = 8,
    parameter int FULL_LAT = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                chip_en,
    input logic                out_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [2*BYTE_W-1:0] rd_data,
    input logic                rd_valid,
    input logic                drive_lo,
    input logic                drive_hi
);
    // R6: standby drops the valid flag at the next edge.
    p_standby_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> !rd_valid);

    // R7: output enable low leaves every lane undriven.
    p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (!drive_lo && !drive_hi && rd_data == '0));

    // R2: the high lane is never driven without the low lane.
    p_hi_needs_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_hi |-> drive_lo);

    // R2: an undriven high lane reads zero.
    p_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_hi |-> (rd_data[2*BYTE_W-1:BYTE_W] == '0));

    // R5: a valid read needs chip enable at the previous edge.
    p_valid_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(chip_en));

    // R3: a group change under chip enable restarts the full wait.
    generate
        if (FULL_LAT > 1) begin : g_restart
            p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (chip_en && !$stable(addr[ADDR_W-1:2])) |=> !rd_valid);
        end
    endgenerate
endmodule

bind rom_burst_port rom_burst_port_chk #(
    .ADDR_W   (ADDR_W),
    .BYTE_W   (BYTE_W),
    .FULL_LAT (FULL_LAT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_en  (chip_en),
    .out_en   (out_en),
    .addr     (addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .drive_lo (drive_lo),
    .drive_hi (drive_hi)
);

// File: tb/rom_burst_port_tb.sv
// Scoreboard bench: the driver queues expected reads, the monitor times them.
module rom_burst_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_en = 1'b0, out_en = 1'b1, word_mode = 1'b1, id_mode = 1'b0;
    logic [17:0] addr = '0;
    logic        byte_lsb = 1'b0;
    logic        bd_we = 1'b0;
    logic [17:0] bd_addr = '0;
    logic [15:0] bd_data = '0;
    logic        erase_all = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid, drive_lo, drive_hi;

    int tests = 0;
    int fails = 0;
    logic busy = 1'b0;
    logic [15:0] model [1024];

    typedef struct {
        int          lat;
        logic [15:0] data;
        logic        hi;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    rom_burst_port u_dut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .out_en(out_en),
        .word_mode(word_mode), .id_mode(id_mode), .addr(addr), .byte_lsb(byte_lsb),
        .bd_we(bd_we), .bd_addr(bd_addr), .bd_data(bd_data), .erase_all(erase_all),
        .rd_data(rd_data), .rd_valid(rd_valid), .drive_lo(drive_lo), .drive_hi(drive_hi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'((i * 16'h0137) ^ 16'hA5C3);
    endfunction

    task automatic bd_write(input int a, input logic [15:0] d);
        @(negedge clk);
        bd_we = 1'b1; bd_addr = 18'(a); bd_data = d;
        @(negedge clk);
        bd_we = 1'b0;
        model[a % 1024] = d;
    endtask

    task automatic do_erase();
        @(negedge clk);
        erase_all = 1'b1;
        @(negedge clk);
        erase_all = 1'b0;
        for (int i = 0; i < 1024; i++) model[i] = 16'hFFFF;
    endtask

    // Driver: apply a read and queue what the monitor must see.
    task automatic req(input logic wm, input logic idm, input int a, input logic lsb,
                       input int lat, input logic [15:0] d, input logic hi, input string tag);
        exp_t e;
        @(negedge clk);
        chip_en = 1'b1; out_en = 1'b1; word_mode = wm; id_mode = idm;
        addr = 18'(a); byte_lsb = lsb;
        e.lat = lat; e.data = d; e.hi = hi; e.tag = tag;
        busy = 1'b1;
        q.push_back(e);
        wait (busy == 1'b0);
    endtask

    // Monitor: pop each expected read and check its timing and data.
    initial begin
        forever begin
            exp_t e;
            wait (q.size() != 0);
            e = q.pop_front();
            repeat (e.lat - 1) @(posedge clk);
            #1;
            if (e.lat > 1) chk({e.tag, " R5 valid low before completion"}, 32'(rd_valid), 32'd0);
            @(posedge clk);
            #1;
            chk({e.tag, " valid"}, 32'(rd_valid), 32'd1);
            chk({e.tag, " data"}, 32'(rd_data), 32'(e.data));
            chk({e.tag, " high lane"}, 32'(drive_hi), 32'(e.hi));
            busy = 1'b0;
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R5 reset valid", 32'(rd_valid), 32'd0);
        chk("R5 reset lanes", 32'({drive_lo, drive_hi}), 32'd0);
        chk("R5 reset data", 32'(rd_data), 32'd0);

        // Storage setup: word 20 is written then erased (R8, R11).
        for (int i = 0; i < 1024; i++) model[i] = 16'hFFFF;
        bd_write(20, 16'h1234);
        do_erase();
        for (int i = 0; i < 16; i++) bd_write(i, pat(i));
        bd_write(32'h3FF, 16'hC0DE);

        // Word view: full, burst, group change (R1, R3, R4, R8).
        req(1, 0, 4, 0, 4, model[4], 1, "R3 R1 word full");
        req(1, 0, 5, 0, 2, model[5], 1, "R4 word burst");
        req(1, 0, 7, 0, 2, model[7], 1, "R4 word burst end");
        req(1, 0, 8, 0, 4, model[8], 1, "R3 group change");
        req(1, 0, 20, 0, 4, 16'hFFFF, 1, "R8 erased word");
        req(1, 0, 32'h403, 0, 4, model[3], 1, "R1 alias");

        // R10: byte_lsb toggled in word view has no effect.
        @(negedge clk);
        byte_lsb = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 valid held", 32'(rd_valid), 32'd1);
        chk("R10 data held", 32'(rd_data), 32'(model[3]));

        // R7: output enable gates lanes without restarting.
        @(negedge clk);
        out_en = 1'b0;
        #1;
        chk("R7 lanes off", 32'({drive_lo, drive_hi}), 32'd0);
        chk("R7 data zero", 32'(rd_data), 32'd0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        out_en = 1'b1;
        #1;
        chk("R7 valid kept", 32'(rd_valid), 32'd1);
        chk("R7 data back", 32'(rd_data), 32'(model[3]));

        // Byte view (R2, R3, R4).
        req(0, 0, 8, 0, 4, {8'h00, model[8][7:0]}, 0, "R2 R3 byte low");
        req(0, 0, 8, 1, 2, {8'h00, model[8][15:8]}, 0, "R2 R4 byte high");
        req(0, 0, 9, 0, 2, {8'h00, model[9][7:0]}, 0, "R2 R4 byte next word");
        req(0, 0, 10, 1, 2, {8'h00, model[10][15:8]}, 0, "R2 R4 byte burst");

        // R6: standby drops valid, ignores address, forces full access.
        @(negedge clk);
        chip_en = 1'b0;
        @(posedge clk);
        #1;
        chk("R6 standby valid", 32'(rd_valid), 32'd0);
        chk("R6 standby lanes", 32'(drive_lo), 32'd0);
        @(negedge clk);
        addr = 18'd11;
        repeat (2) @(posedge clk);
        #1;
        chk("R6 address ignored", 32'(rd_valid), 32'd0);
        req(0, 0, 11, 0, 4, {8'h00, model[11][7:0]}, 0, "R6 full after standby");

        // R9: identifier codes.
        req(1, 1, 32'h22, 0, 4, 16'h0007, 1, "R9 maker code");
        req(1, 1, 32'h23, 0, 2, 16'h00A1, 1, "R9 device code");

        // R11: backdoor writes reach reads.
        req(1, 0, 32'h3FF, 0, 4, 16'hC0DE, 1, "R11 top word");
        bd_write(5, 16'h5AA5);
        req(1, 0, 5, 0, 4, 16'h5AA5, 1, "R11 overwrite");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule